// File: doc/BRIEF.md
# Precise Pipeline Exception Unit

This unit keeps exceptions precise in a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). A fault can be detected in any stage. The unit does not act on it at once. It records the fault in a small status vector, and that vector travels with the instruction through the pipeline latches. Each stage's detection logic reaches the unit as a plain flag input for the instruction that occupies that stage in the current cycle.

The decision point is the memory stage. When the instruction there has any bit set in its vector, the unit takes the exception in that cycle:
- it picks one cause by a fixed priority;
- it blocks the instruction's store;
- it empties every latch that holds this instruction or a younger one;
- it strobes the write enables of its exception-PC and cause registers;
- it redirects fetch.

The redirect target is either a fixed handler address or, in vectored mode, a base plus sixteen bytes per cause code. Instructions older than the faulting one have already moved to writeback and complete normally.

An external interrupt request is attached to the oldest instruction still in flight. It is then taken when that instruction reaches the memory stage, with the exception PC pointing at that instruction. If nothing is in flight, the request waits until an instruction is fetched.

Top module: `precise_exc_unit`

## Requirements
- R1: An instruction presented with `fetch_valid` high in cycle c is reported on `wb_commit`/`wb_pc` in cycle c+4, unless an exception is taken while it is in flight.
- R2: A fault flagged in any stage is acted on only in the cycle its instruction occupies the memory stage (cycle c+3): `exc_take` and `redirect_valid` rise in that cycle and not earlier.
- R3: Exceptions are taken in program order. An older instruction's memory-stage fault wins over a younger instruction's fault, even if the younger fault was flagged in an earlier cycle. The younger fault is then discarded.
- R4: Cause codes are: 0 undefined opcode, 1 arithmetic overflow, 2 fetch page fault, 3 fetch misaligned, 4 fetch protection, 5 data page fault, 6 data misaligned, 7 data protection, 8 external interrupt. When one instruction carries several causes, the order of preference is 8, 3, 2, 4, 0, 1, 6, 5, 7.
- R5: When an exception is taken, the faulting instruction, every younger instruction and the instruction fetched in that cycle never commit. The instruction already in writeback still commits.
- R6: `mem_store_en` is high only for a valid memory-stage store whose instruction is not taking an exception.
- R7: `epc_we` and `cause_we` are high exactly in the cycle of a take. `epc` and `cause` show the faulting PC and the cause from the next cycle on, and hold their value until the next take.
- R8: With `vec_mode` low, `redirect_pc` during a take equals the parameter `HANDLER_ADDR` (default 0x80).
- R9: With `vec_mode` high, `redirect_pc` during a take equals `vec_base + cause*16`.
- R10: An `irq_req` pulse is attached to the oldest valid instruction among the memory, execute and decode stages and the instruction being fetched, and is reported with cause 8 and that instruction's PC. With no instruction in flight, the request is held until one is fetched.
- R11: After reset, `epc` and `cause` are zero and the pipeline is empty, so fault flags alone cause no take and no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | An instruction is fetched this cycle |
| fetch_pc | input | XLEN | PC of the fetched instruction |
| if_page_fault | input | 1 | Fetch page fault for the fetched instruction |
| if_misaligned | input | 1 | Fetch misaligned access |
| if_prot_viol | input | 1 | Fetch protection violation |
| id_undef_op | input | 1 | Decode found an undefined or illegal opcode |
| ex_overflow | input | 1 | Execute stage arithmetic overflow |
| mem_page_fault | input | 1 | Data page fault in the memory stage |
| mem_misaligned | input | 1 | Data misaligned access |
| mem_prot_viol | input | 1 | Data protection violation |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| irq_req | input | 1 | External interrupt request pulse |
| vec_mode | input | 1 | 1 selects vectored handler addresses |
| vec_base | input | XLEN | Base of the vectored handler table |
| exc_take | output | 1 | Exception taken this cycle; pipeline flushed |
| epc_we | output | 1 | Exception PC register write enable |
| cause_we | output | 1 | Cause register write enable |
| epc | output | XLEN | Saved PC of the faulting instruction |
| cause | output | CAUSE_W | Saved cause code |
| redirect_valid | output | 1 | Fetch must restart at `redirect_pc` |
| redirect_pc | output | XLEN | Handler address |
| mem_store_en | output | 1 | Memory write permitted this cycle |
| wb_commit | output | 1 | An instruction commits in writeback |
| wb_pc | output | XLEN | PC of the committing instruction |

## Verification
A status vector that is lost or assigned to the wrong instruction shows at the ports in one of three ways. There may be no take three cycles after the flagged fetch. There may be a take on the wrong cycle. Or `epc` one cycle later may point at the wrong instruction. An incomplete flush shows as a stray `wb_commit` within four cycles after the take, or as a second take from a younger instruction's stale flag. A wrong priority or attachment of an interrupt appears in `cause` and `redirect_pc` in the cycle of the take or the cycle after it.

// File: rtl/precise_exc_unit.sv
module precise_exc_unit #(
  parameter int XLEN = 32,
  parameter int CAUSE_W = 4,
  parameter int VEC_SHIFT = 4,
  parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h0000_0080
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_valid,
  input  logic [XLEN-1:0]    fetch_pc,
  input  logic               if_page_fault,
  input  logic               if_misaligned,
  input  logic               if_prot_viol,
  input  logic               id_undef_op,
  input  logic               ex_overflow,
  input  logic               mem_page_fault,
  input  logic               mem_misaligned,
  input  logic               mem_prot_viol,
  input  logic               mem_is_store,
  input  logic               irq_req,
  input  logic               vec_mode,
  input  logic [XLEN-1:0]    vec_base,
  output logic               exc_take,
  output logic               epc_we,
  output logic               cause_we,
  output logic [XLEN-1:0]    epc,
  output logic [CAUSE_W-1:0] cause,
  output logic               redirect_valid,
  output logic [XLEN-1:0]    redirect_pc,
  output logic               mem_store_en,
  output logic               wb_commit,
  output logic [XLEN-1:0]    wb_pc
);

  localparam int NC = 9;
  localparam int C_UNDEF = 0, C_OVF = 1, C_IPF = 2, C_IMIS = 3, C_IPROT = 4;
  localparam int C_DPF = 5, C_DMIS = 6, C_DPROT = 7, C_IRQ = 8;
  localparam int PRIO [NC] = '{C_IRQ, C_IMIS, C_IPF, C_IPROT, C_UNDEF, C_OVF, C_DMIS, C_DPF, C_DPROT};

  logic            id_v, ex_v, mem_v, wb_v, irq_pend;
  logic [XLEN-1:0] id_pc, ex_pc, mem_pc, wb_pc_q, epc_q;
  logic [NC-1:0]   id_x, ex_x, mem_x;
  logic [CAUSE_W-1:0] cause_q, sel;
  logic [NC-1:0]   f_full, id_full, ex_full, mem_full;
  logic            irq_any, irq_to_mem, irq_to_ex, irq_to_id, irq_to_if, take;

  assign irq_any    = irq_req | irq_pend;
  assign irq_to_mem = irq_any & mem_v;
  assign irq_to_ex  = irq_any & ~mem_v & ex_v;
  assign irq_to_id  = irq_any & ~mem_v & ~ex_v & id_v;
  assign irq_to_if  = irq_any & ~mem_v & ~ex_v & ~id_v & fetch_valid;

  always_comb begin
    f_full = '0;
    f_full[C_IPF]   = if_page_fault;
    f_full[C_IMIS]  = if_misaligned;
    f_full[C_IPROT] = if_prot_viol;
    f_full[C_IRQ]   = irq_to_if;
    id_full = id_x;
    id_full[C_UNDEF] = id_x[C_UNDEF] | id_undef_op;
    id_full[C_IRQ]   = id_x[C_IRQ] | irq_to_id;
    ex_full = ex_x;
    ex_full[C_OVF] = ex_x[C_OVF] | ex_overflow;
    ex_full[C_IRQ] = ex_x[C_IRQ] | irq_to_ex;
    mem_full = mem_x;
    mem_full[C_DPF]   = mem_x[C_DPF] | mem_page_fault;
    mem_full[C_DMIS]  = mem_x[C_DMIS] | mem_misaligned;
    mem_full[C_DPROT] = mem_x[C_DPROT] | mem_prot_viol;
    mem_full[C_IRQ]   = mem_x[C_IRQ] | irq_to_mem;
  end

  always_comb begin
    sel = '0;
    for (int k = NC - 1; k >= 0; k--)
      if (mem_full[PRIO[k]]) sel = CAUSE_W'(PRIO[k]);
  end

  assign take           = mem_v & (|mem_full);
  assign exc_take       = take;
  assign epc_we         = take;
  assign cause_we       = take;
  assign redirect_valid = take;
  assign redirect_pc    = vec_mode ? vec_base + (XLEN'(sel) << VEC_SHIFT) : HANDLER_ADDR;
  assign mem_store_en   = mem_v & mem_is_store & ~take;
  assign wb_commit      = wb_v;
  assign wb_pc          = wb_pc_q;
  assign epc            = epc_q;
  assign cause          = cause_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_v <= 1'b0; ex_v <= 1'b0; mem_v <= 1'b0; wb_v <= 1'b0;
      id_x <= '0; ex_x <= '0; mem_x <= '0;
      id_pc <= '0; ex_pc <= '0; mem_pc <= '0; wb_pc_q <= '0;
      epc_q <= '0; cause_q <= '0; irq_pend <= 1'b0;
    end else begin
      irq_pend <= irq_any & ~(mem_v | ex_v | id_v | fetch_valid);
      if (take) begin
        id_v <= 1'b0; ex_v <= 1'b0; mem_v <= 1'b0; wb_v <= 1'b0;
        id_x <= '0; ex_x <= '0; mem_x <= '0;
        epc_q   <= mem_pc;
        cause_q <= sel;
      end else begin
        id_v    <= fetch_valid;
        id_pc   <= fetch_pc;
        id_x    <= fetch_valid ? f_full : '0;
        ex_v    <= id_v;
        ex_pc   <= id_pc;
        ex_x    <= id_v ? id_full : '0;
        mem_v   <= ex_v;
        mem_pc  <= ex_pc;
        mem_x   <= ex_v ? ex_full : '0;
        wb_v    <= mem_v;
        wb_pc_q <= mem_pc;
      end
    end
  end

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !(id_v || ex_v || mem_v || wb_commit)); // R5
  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(cause)); // R7
  AST_EPC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(epc)); // R7
  AST_IRQ_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_to_mem, irq_to_ex, irq_to_id, irq_to_if})); // R10
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_mode) |-> redirect_pc[VEC_SHIFT-1:0] == vec_base[VEC_SHIFT-1:0]); // R9
  AST_COMMIT_FROM_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    wb_commit |-> $past(mem_v) && !$past(take)); // R1
  AST_LEGAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> cause < CAUSE_W'(NC)); // R4

endmodule

// File: tb/precise_exc_unit_tb.sv
module precise_exc_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fetch_valid = 0, if_page_fault = 0, if_misaligned = 0, if_prot_viol = 0;
  logic id_undef_op = 0, ex_overflow = 0, mem_page_fault = 0, mem_misaligned = 0;
  logic mem_prot_viol = 0, mem_is_store = 0, irq_req = 0, vec_mode = 0;
  logic [31:0] fetch_pc = '0, vec_base = '0;
  logic exc_take, epc_we, cause_we, redirect_valid, mem_store_en, wb_commit;
  logic [31:0] epc, redirect_pc, wb_pc;
  logic [3:0] cause;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  precise_exc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .if_page_fault(if_page_fault), .if_misaligned(if_misaligned), .if_prot_viol(if_prot_viol),
    .id_undef_op(id_undef_op), .ex_overflow(ex_overflow), .mem_page_fault(mem_page_fault),
    .mem_misaligned(mem_misaligned), .mem_prot_viol(mem_prot_viol), .mem_is_store(mem_is_store),
    .irq_req(irq_req), .vec_mode(vec_mode), .vec_base(vec_base), .exc_take(exc_take),
    .epc_we(epc_we), .cause_we(cause_we), .epc(epc), .cause(cause),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .mem_store_en(mem_store_en),
    .wb_commit(wb_commit), .wb_pc(wb_pc));

  typedef struct packed {
    logic fv; logic [15:0] fpc; logic [2:0] ifx; logic idu; logic exo; logic [2:0] mx;
    logic st; logic irq; logic tk; logic [15:0] rpc; logic sten; logic com;
    logic [15:0] wpc; logic [15:0] epc; logic [3:0] cs;
  } row_t;

  // ifx = {page fault, misaligned, protection}; mx likewise for data faults
  localparam int NROW = 31;
  localparam row_t TBL [NROW] = '{
    '{1'b1,16'h100,3'b000,1'b0,1'b0,3'b000,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0,16'h000,16'h000,4'd0},
    '{1'b1,16'h104,3'b000,1'b0,1'b0,3'b000,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0,16'h000,16'h000,4'd0},
    '{1'b1,16'h108,3'b000,1'b0,1'b0,3'b000,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0,16'h000,16'h000,4'd0},
    '{1'b1,16'h10C,3'b000,1'b0,1'b0,3'b000,1'b1,1'b0, 1'b0,16'h0,1'b1,1'b0,16'h000,16'h000,4'd0}, // R6 clean store
    '{1'b1,16'h110,3'b000,1'b0,1'b0,3'b000,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b1,16'h100,16'h000,4'd0}, // R1
    '{1'b1,16'h114,3'b000,1'b0,1'b1,3'b000,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b1,16'h104,16'h000,4'd0}, // overflow on 10C
    '{1'b1,16'h118,3'b000,1'b0,1'b0,3'b000,1'b1,1'b0, 1'b1,16'h80,1'b0,1'b1,16'h108,16'h000,4'd0}, // R2 R5 R6 R8
    '{1'b1,16'h080,3'b000,1'b0,1'b0,3'b000,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0,16'h000,16'h10C,4'd1}, // R7
    '{1'b1,16'h084,3'b000,1'b1,1'b0,3'b000,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0,16'h000,16'h10C,4'd1},
    '{1'b1,16'h088,3'b100,1'b0,1'b0,3'b000,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0,16'h000,16'h10C,4'd1},
    '{1'b1,16'h08C,3'b000,1'b0,1'b0,3'b000,1'b0,1'b0, 1'b1,16'h80,1'b0,1'b0,16'h000,16'h10C,4'd1},
    '{1'b1,16'h080,3'b000,1'b0,1'b0,3'b000,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0,16'h000,16'h080,4'd0},
    '{1'b1,16'h084,3'b010,1'b0,1'b0,3'b000,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0,16'h000,16'h080,4'd0}, // younger fault first
    '{1'b1,16'h088,3'b000,1'b0,1'b0,3'b000,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0,16'h000,16'h080,4'd0},
    '{1'b1,16'h08C,3'b000,1'b0,1'b0,3'b100,1'b0,1'b0, 1'b1,16'h80,1'b0,1'b0,16'h000,16'h080,4'd0}, // R3 older wins
    '{1'b1,16'h090,3'b000,1'b0,1'b0,3'b000,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0,16'h000,16'h080,4'd5},
    '{1'b1,16'h094,3'b000,1'b0,1'b0,3'b000,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0,16'h000,16'h080,4'd5},
    '{1'b0,16'h000,3'b000,1'b0,1'b0,3'b000,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0,16'h000,16'h080,4'd5},
    '{1'b0,16'h000,3'b000,1'b0,1'b0,3'b000,1'b1,1'b1, 1'b1,16'h80,1'b0,1'b0,16'h000,16'h080,4'd5}, // R10 irq on MEM
    '{1'b0,16'h000,3'b000,1'b0,1'b0,3'b000,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0,16'h000,16'h090,4'd8},
    '{1'b1,16'h200,3'b000,1'b0,1'b0,3'b000,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0,16'h000,16'h090,4'd8},
    '{1'b0,16'h000,3'b000,1'b0,1'b0,3'b000,1'b0,1'b1, 1'b0,16'h0,1'b0,1'b0,16'h000,16'h090,4'd8}, // R10 irq on ID
    '{1'b0,16'h000,3'b000,1'b0,1'b0,3'b000,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0,16'h000,16'h090,4'd8},
    '{1'b0,16'h000,3'b000,1'b0,1'b0,3'b001,1'b0,1'b0, 1'b1,16'h80,1'b0,1'b0,16'h000,16'h090,4'd8}, // R4 irq over data prot
    '{1'b0,16'h000,3'b000,1'b0,1'b0,3'b000,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0,16'h000,16'h200,4'd8},
    '{1'b0,16'h000,3'b000,1'b0,1'b0,3'b000,1'b0,1'b1, 1'b0,16'h0,1'b0,1'b0,16'h000,16'h200,4'd8}, // R10 held pending
    '{1'b1,16'h300,3'b000,1'b0,1'b0,3'b000,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0,16'h000,16'h200,4'd8},
    '{1'b0,16'h000,3'b000,1'b0,1'b0,3'b000,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0,16'h000,16'h200,4'd8},
    '{1'b0,16'h000,3'b000,1'b0,1'b0,3'b000,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0,16'h000,16'h200,4'd8},
    '{1'b0,16'h000,3'b000,1'b0,1'b0,3'b000,1'b0,1'b0, 1'b1,16'h80,1'b0,1'b0,16'h000,16'h200,4'd8},
    '{1'b0,16'h000,3'b000,1'b0,1'b0,3'b000,1'b0,1'b0, 1'b0,16'h0,1'b0,1'b0,16'h000,16'h300,4'd8}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(logic fv, logic [31:0] pc, logic [2:0] ifx, logic idu, logic exo,
                     logic [2:0] mx, logic st, logic irq);
    @(negedge clk);
    fetch_valid = fv; fetch_pc = pc;
    {if_page_fault, if_misaligned, if_prot_viol} = ifx;
    id_undef_op = idu; ex_overflow = exo;
    {mem_page_fault, mem_misaligned, mem_prot_viol} = mx;
    mem_is_store = st; irq_req = irq;
    #5;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R11 epc after reset", epc, 32'h0);
    chk("R11 cause after reset", 32'(cause), 32'h0);
    chk("R11 take after reset", 32'(exc_take), 32'h0);
    chk("R11 commit after reset", 32'(wb_commit), 32'h0);

    for (int i = 0; i < NROW; i++) begin
      cyc(TBL[i].fv, {16'h0, TBL[i].fpc}, TBL[i].ifx, TBL[i].idu, TBL[i].exo,
          TBL[i].mx, TBL[i].st, TBL[i].irq);
      chk("R2 exc_take", 32'(exc_take), 32'(TBL[i].tk));
      chk("R7 epc_we", 32'(epc_we), 32'(TBL[i].tk));
      if (TBL[i].tk) chk("R8 redirect_pc", redirect_pc, {16'h0, TBL[i].rpc});
      chk("R6 mem_store_en", 32'(mem_store_en), 32'(TBL[i].sten));
      chk("R5 wb_commit", 32'(wb_commit), 32'(TBL[i].com));
      if (TBL[i].com) chk("R1 wb_pc", wb_pc, {16'h0, TBL[i].wpc});
      chk("R7 epc", epc, {16'h0, TBL[i].epc});
      chk("R10 cause", 32'(cause), 32'(TBL[i].cs));
    end

    // R9 and R4: vectored mode, fetch protection beats a later undefined opcode
    vec_mode = 1'b1; vec_base = 32'h0000_1000;
    cyc(1'b1, 32'h400, 3'b001, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0);
    cyc(1'b0, 32'h0, 3'b000, 1'b1, 1'b0, 3'b000, 1'b0, 1'b0);
    cyc(1'b0, 32'h0, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0);
    chk("R2 no early take", 32'(exc_take), 32'h0);
    cyc(1'b0, 32'h0, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0);
    chk("R2 take at memory stage", 32'(exc_take), 32'h1);
    chk("R9 vectored target", redirect_pc, 32'h1040);
    cyc(1'b0, 32'h0, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0);
    chk("R4 priority cause", 32'(cause), 32'd4);
    chk("R7 epc vectored", epc, 32'h400);

    // R3: older data misaligned and younger overflow in the same cycle
    cyc(1'b1, 32'h500, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0);
    cyc(1'b1, 32'h504, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0);
    cyc(1'b0, 32'h0, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0);
    cyc(1'b0, 32'h0, 3'b000, 1'b0, 1'b1, 3'b010, 1'b0, 1'b0);
    chk("R3 take older", 32'(exc_take), 32'h1);
    chk("R9 vectored target 6", redirect_pc, 32'h1060);
    cyc(1'b0, 32'h0, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0);
    chk("R3 cause of older", 32'(cause), 32'd6);
    chk("R3 epc of older", epc, 32'h500);
    for (int k = 0; k < 4; k++) begin
      cyc(1'b0, 32'h0, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0);
      chk("R5 younger flushed no take", 32'(exc_take), 32'h0);
      chk("R5 younger flushed no commit", 32'(wb_commit), 32'h0);
    end

    // R11: reset mid-flight empties the pipeline
    cyc(1'b1, 32'h600, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0);
    cyc(1'b1, 32'h604, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b0; fetch_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      cyc(1'b0, 32'h0, 3'b000, 1'b0, 1'b0, 3'b111, 1'b0, 1'b0);
      chk("R11 no take after reset", 32'(exc_take), 32'h0);
      chk("R11 no commit after reset", 32'(wb_commit), 32'h0);
    end
    chk("R11 epc cleared", epc, 32'h0);
    chk("R11 cause cleared", 32'(cause), 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule